// File: doc/BRIEF.md
# Miss fill buffer allocator

This block tracks first-level cache misses that are waiting on the rest of the memory hierarchy. It holds a small pool of fill entries. Every miss that leaves the core must own one entry for as long as the miss is outstanding. Two core request ports can ask for entries in the same cycle. A request is a demand load, a store, a non-temporal store or a software prefetch, and a prefetch carries a hint that names the cache level it targets. No request kind bypasses the pool.

When a request misses, the block gives it the lowest-numbered free entry. The entry index goes downstream as a tag. The entry is freed when a response comes back with that tag and with the release kind that belongs to the request:
- A demand access and a first-level prefetch wait for the fill.
- A prefetch that stops at the second level or beyond waits only until the second level takes the line.
- A non-temporal store waits only until the next-level queue accepts it.

A request to a line that already has a live entry joins that entry. When no entry is available, the request is held back with its ready low; it is never dropped. Each denied request adds one to a full-event counter. Both ports can be denied in the same cycle, so the counter can grow faster than the cycle count.

Top module: `fill_buf_alloc`

## Requirements
- R1: After reset all entries are free and `full_cnt_o` is 0.
- R2: A valid request whose line matches no live entry, while an entry is free, is accepted in the same cycle (ready high). It takes the lowest-indexed free entry, and that index is reported on `alloc_valid_o`/`alloc_tag_o` of its port. Kind codes: load 0, store 1, non-temporal store 2, prefetch 3.
- R3: The pool holds `NUM_ENTRIES` (default 10) entries. When all are busy, a new-line request of any kind, prefetches included, gets ready low and no allocation. It is accepted once an entry has been freed.
- R4: `full_cnt_o` grows by the number of valid requests that are not accepted in a cycle: 0, 1 or 2. The new value is visible after the next rising edge.
- R5: A request whose line address equals that of a live entry is accepted without allocating and without counting, even when the pool is full.
- R6: When both ports request the same line in one cycle and port 0 is accepted, port 1 is accepted as well and allocates nothing.
- R7: When both ports need a new entry and only one is free, port 0 gets it, and port 1 is denied and counted.
- R8: A response of kind fill (code 2) frees an entry that holds a load, a store, or a prefetch with hint first-level (0) or non-temporal (3).
- R9: A response of kind second-level-ready (code 1) frees an entry that holds a prefetch with hint second-level (1) or last-level (2).
- R10: A response of kind queued (code 0) frees an entry that holds a non-temporal store.
- R11: A response has no effect if its kind is not the one that frees the addressed entry, or if its tag names a free entry or an index at or above `NUM_ENTRIES`.
- R12: An entry freed by a response cannot be reallocated in that cycle. It can be reallocated from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 2 | Request valid, one bit per port |
| req_line_i | input | 2 x LINE_W | 64-byte line address per port |
| req_kind_i | input | 2 x 2 | Request kind per port |
| req_hint_i | input | 2 x 2 | Prefetch target hint per port |
| req_ready_o | output | 2 | Request accepted this cycle (allocated or merged) |
| alloc_valid_o | output | 2 | A new entry was allocated for this port |
| alloc_tag_o | output | 2 x TAG_W | Index of the allocated entry |
| rsp_valid_i | input | 1 | Downstream response valid |
| rsp_tag_i | input | TAG_W | Entry addressed by the response |
| rsp_kind_i | input | 2 | Response kind: queued, second-level-ready, fill |
| full_cnt_o | output | CNT_W | Count of denied requests |

## Verification
The bench builds the block with its defaults: 10 entries, a 40-bit address (34-bit line) and a 32-bit counter. With ten entries, a few dual-port cycles fill the pool. That brings within reach full-pool stalls, double denials, port-0 priority over the last entry and release-then-reallocate timing. The random phase draws lines from a set of only sixteen, so merges with live entries and same-cycle same-line pairs happen often. Response tags run up to 11, which covers tags beyond the pool.

// File: rtl/fb_pkg.sv
package fb_pkg;

  typedef enum logic [1:0] {
    REQ_LOAD     = 2'd0,
    REQ_STORE    = 2'd1,
    REQ_NT_STORE = 2'd2,
    REQ_PREFETCH = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    HINT_L1  = 2'd0,
    HINT_L2  = 2'd1,
    HINT_LLC = 2'd2,
    HINT_NTA = 2'd3
  } pf_hint_e;

  typedef enum logic [1:0] {
    RSP_QUEUED   = 2'd0,
    RSP_L2_READY = 2'd1,
    RSP_FILL     = 2'd2,
    RSP_NONE     = 2'd3
  } rsp_kind_e;

  // response kind that retires an entry of the given type
  function automatic rsp_kind_e release_on(req_kind_e kind, pf_hint_e hint);
    if (kind == REQ_NT_STORE) return RSP_QUEUED;
    if (kind == REQ_PREFETCH && (hint == HINT_L2 || hint == HINT_LLC)) return RSP_L2_READY;
    return RSP_FILL;
  endfunction

endpackage

// File: rtl/fb_prio_enc.sv
module fb_prio_enc #(
  parameter int unsigned N     = 10,
  parameter int unsigned IDX_W = 4
) (
  input  logic [N-1:0]     free_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);

  // lowest index wins: scan downward, last hit sticks
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/fb_entry.sv
module fb_entry import fb_pkg::*; #(
  parameter int unsigned LINE_W = 34
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [LINE_W-1:0] alloc_line_i,
  input  logic [1:0]        alloc_kind_i,
  input  logic [1:0]        alloc_hint_i,
  input  logic              rsp_hit_i,
  input  logic [1:0]        rsp_kind_i,
  input  logic [LINE_W-1:0] lk_line0_i,
  input  logic [LINE_W-1:0] lk_line1_i,
  output logic              valid_o,
  output logic              hit0_o,
  output logic              hit1_o,
  output logic              release_o
);

  logic              valid_q;
  logic [LINE_W-1:0] line_q;
  req_kind_e         kind_q;
  pf_hint_e          hint_q;

  assign valid_o   = valid_q;
  assign hit0_o    = valid_q && (line_q == lk_line0_i);
  assign hit1_o    = valid_q && (line_q == lk_line1_i);
  assign release_o = valid_q && rsp_hit_i && (rsp_kind_i == release_on(kind_q, hint_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      line_q  <= '0;
      kind_q  <= REQ_LOAD;
      hint_q  <= HINT_L1;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      line_q  <= alloc_line_i;
      kind_q  <= req_kind_e'(alloc_kind_i);
      hint_q  <= pf_hint_e'(alloc_hint_i);
    end else if (release_o) begin
      valid_q <= 1'b0;
    end
  end

  // R2
  alloc_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !valid_q);

  // R12
  no_same_cycle_realloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |-> !alloc_i);

endmodule

// File: rtl/fb_full_cnt.sv
module fb_full_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       deny_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(deny_i[0]) + CNT_W'(deny_i[1]);
  end

endmodule

// File: rtl/fill_buf_alloc.sv
module fill_buf_alloc import fb_pkg::*; #(
  parameter int unsigned NUM_ENTRIES = 10,
  parameter int unsigned ADDR_W      = 40,
  parameter int unsigned LINE_BYTES  = 64,
  parameter int unsigned CNT_W       = 32,
  localparam int unsigned OFF_W      = $clog2(LINE_BYTES),
  localparam int unsigned LINE_W     = ADDR_W - OFF_W,
  localparam int unsigned TAG_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [1:0]                  req_valid_i,
  input  logic [1:0][LINE_W-1:0]      req_line_i,
  input  logic [1:0][1:0]             req_kind_i,
  input  logic [1:0][1:0]             req_hint_i,
  output logic [1:0]                  req_ready_o,
  output logic [1:0]                  alloc_valid_o,
  output logic [1:0][TAG_W-1:0]       alloc_tag_o,
  input  logic                        rsp_valid_i,
  input  logic [TAG_W-1:0]            rsp_tag_i,
  input  logic [1:0]                  rsp_kind_i,
  output logic [CNT_W-1:0]            full_cnt_o
);

  logic [NUM_ENTRIES-1:0] valid, hit0, hit1, rel;
  logic [NUM_ENTRIES-1:0] free0, free1, pick0_oh;
  logic                   found0, found1;
  logic [TAG_W-1:0]       pick0, pick1;
  logic                   alloc0, alloc1, acc0, acc1, same_line;

  // entries
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic sel0, sel1;
    assign sel0 = alloc0 && (pick0 == TAG_W'(i));
    assign sel1 = alloc1 && (pick1 == TAG_W'(i));

    fb_entry #(.LINE_W(LINE_W)) u_entry (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .alloc_i      (sel0 || sel1),
      .alloc_line_i (sel0 ? req_line_i[0] : req_line_i[1]),
      .alloc_kind_i (sel0 ? req_kind_i[0] : req_kind_i[1]),
      .alloc_hint_i (sel0 ? req_hint_i[0] : req_hint_i[1]),
      .rsp_hit_i    (rsp_valid_i && (rsp_tag_i == TAG_W'(i))),
      .rsp_kind_i   (rsp_kind_i),
      .lk_line0_i   (req_line_i[0]),
      .lk_line1_i   (req_line_i[1]),
      .valid_o      (valid[i]),
      .hit0_o       (hit0[i]),
      .hit1_o       (hit1[i]),
      .release_o    (rel[i])
    );
  end

  // port 0 picks first; port 1 sees what is left
  assign free0 = ~valid;

  fb_prio_enc #(.N(NUM_ENTRIES), .IDX_W(TAG_W)) u_enc0 (
    .free_i  (free0),
    .found_o (found0),
    .idx_o   (pick0)
  );

  assign pick0_oh = alloc0 ? (NUM_ENTRIES'(1) << pick0) : '0;
  assign free1    = free0 & ~pick0_oh;

  fb_prio_enc #(.N(NUM_ENTRIES), .IDX_W(TAG_W)) u_enc1 (
    .free_i  (free1),
    .found_o (found1),
    .idx_o   (pick1)
  );

  always_comb begin
    acc0      = req_valid_i[0] && ((|hit0) || found0);
    alloc0    = req_valid_i[0] && !(|hit0) && found0;
    same_line = acc0 && (req_line_i[0] == req_line_i[1]);
    acc1      = req_valid_i[1] && ((|hit1) || same_line || found1);
    alloc1    = req_valid_i[1] && !(|hit1) && !same_line && found1;
  end

  assign req_ready_o    = {acc1, acc0};
  assign alloc_valid_o  = {alloc1, alloc0};
  assign alloc_tag_o[0] = pick0;
  assign alloc_tag_o[1] = pick1;

  fb_full_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .deny_i (req_valid_i & ~req_ready_o),
    .cnt_o  (full_cnt_o)
  );

  // R4
  denied_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i[0] && !req_ready_o[0]) |=> (full_cnt_o != $past(full_cnt_o)));

  // R4
  idle_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&(~req_valid_i | req_ready_o)) |=> $stable(full_cnt_o));

  // R7
  port_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&req_valid_i && !req_ready_o[0]) |-> !alloc_valid_o[1]);

  // R2
  tag_distinct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&alloc_valid_o) |-> (alloc_tag_o[0] != alloc_tag_o[1]));

  // R2
  alloc_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_valid_o[0] |-> req_ready_o[0]);

endmodule

// File: tb/tb_fill_buf_alloc.sv
module tb_fill_buf_alloc;

  localparam int N      = 10;
  localparam int ADDR_W = 40;
  localparam int LINE_W = 34;
  localparam int TAG_W  = 4;
  localparam int CNT_W  = 32;

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic [1:0]             req_valid_i = '0;
  logic [1:0][LINE_W-1:0] req_line_i = '0;
  logic [1:0][1:0]        req_kind_i = '0;
  logic [1:0][1:0]        req_hint_i = '0;
  logic [1:0]             req_ready_o;
  logic [1:0]             alloc_valid_o;
  logic [1:0][TAG_W-1:0]  alloc_tag_o;
  logic                   rsp_valid_i = 1'b0;
  logic [TAG_W-1:0]       rsp_tag_i = '0;
  logic [1:0]             rsp_kind_i = 2'd3;
  logic [CNT_W-1:0]       full_cnt_o;

  fill_buf_alloc #(.NUM_ENTRIES(N), .ADDR_W(ADDR_W), .LINE_BYTES(64), .CNT_W(CNT_W)) dut (
    .clk_i, .rst_ni, .req_valid_i, .req_line_i, .req_kind_i, .req_hint_i,
    .req_ready_o, .alloc_valid_o, .alloc_tag_o,
    .rsp_valid_i, .rsp_tag_i, .rsp_kind_i, .full_cnt_o
  );

  always #5 clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  bit              m_valid [N];
  logic [LINE_W-1:0] m_line [N];
  logic [1:0]      m_kind [N];
  logic [1:0]      m_hint [N];
  longint          m_cnt = 0;

  task automatic chk(input string r, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_rel(input logic [1:0] k, input logic [1:0] h);
    if (k == 2'd2) return 2'd0;
    if (k == 2'd3 && (h == 2'd1 || h == 2'd2)) return 2'd1;
    return 2'd2;
  endfunction

  function automatic int lowest_free(input bit [N-1:0] busy);
    for (int i = 0; i < N; i++) if (!busy[i]) return i;
    return -1;
  endfunction

  task automatic set_req(input int p, input bit v, input longint line, input int k, input int h);
    req_valid_i[p] = v;
    req_line_i[p]  = LINE_W'(line);
    req_kind_i[p]  = 2'(k);
    req_hint_i[p]  = 2'(h);
  endtask

  task automatic set_rsp(input bit v, input int tag, input int k);
    rsp_valid_i = v;
    rsp_tag_i   = TAG_W'(tag);
    rsp_kind_i  = 2'(k);
  endtask

  // called just after a negedge with inputs set; returns at the next negedge
  task automatic step(input string r);
    bit [N-1:0] busy, busy1;
    bit h0, h1, same, r0, r1, a0, a1;
    int t0, t1;
    #1;
    chk(r, "full_cnt", longint'(full_cnt_o), m_cnt);
    h0 = 0; h1 = 0;
    for (int i = 0; i < N; i++) begin
      busy[i] = m_valid[i];
      if (m_valid[i] && m_line[i] == req_line_i[0]) h0 = 1;
      if (m_valid[i] && m_line[i] == req_line_i[1]) h1 = 1;
    end
    t0 = lowest_free(busy);
    r0 = req_valid_i[0] && (h0 || t0 >= 0);
    a0 = req_valid_i[0] && !h0 && t0 >= 0;
    busy1 = busy;
    if (a0) busy1[t0] = 1'b1;
    same = r0 && (req_line_i[0] == req_line_i[1]);
    t1 = lowest_free(busy1);
    r1 = req_valid_i[1] && (h1 || same || t1 >= 0);
    a1 = req_valid_i[1] && !h1 && !same && t1 >= 0;
    chk(r, "ready0", req_ready_o[0], r0);
    chk(r, "ready1", req_ready_o[1], r1);
    chk(r, "alloc0", alloc_valid_o[0], a0);
    chk(r, "alloc1", alloc_valid_o[1], a1);
    if (a0) chk(r, "tag0", alloc_tag_o[0], t0);
    if (a1) chk(r, "tag1", alloc_tag_o[1], t1);
    if (rsp_valid_i && rsp_tag_i < N && m_valid[rsp_tag_i] &&
        rsp_kind_i == exp_rel(m_kind[rsp_tag_i], m_hint[rsp_tag_i]))
      m_valid[rsp_tag_i] = 0;
    if (a0) begin
      m_valid[t0] = 1; m_line[t0] = req_line_i[0];
      m_kind[t0] = req_kind_i[0]; m_hint[t0] = req_hint_i[0];
    end
    if (a1) begin
      m_valid[t1] = 1; m_line[t1] = req_line_i[1];
      m_kind[t1] = req_kind_i[1]; m_hint[t1] = req_hint_i[1];
    end
    m_cnt += longint'(req_valid_i[0] && !r0) + longint'(req_valid_i[1] && !r1);
    @(negedge clk_i);
  endtask

  task automatic idle();
    set_req(0, 0, 0, 0, 0);
    set_req(1, 0, 0, 0, 0);
    set_rsp(0, 0, 3);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_line[i] = '0; m_kind[i] = '0; m_hint[i] = '0;
    end
    repeat (3) @(negedge clk_i);
    chk("R1", "full_cnt in reset", longint'(full_cnt_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: idle after reset, counter zero
    idle(); step("R1");

    // R2: fill the pool with every kind and hint
    set_req(0, 1, 100, 0, 0); set_req(1, 1, 101, 1, 0); step("R2");
    set_req(0, 1, 102, 2, 0); set_req(1, 1, 103, 3, 0); step("R2");
    set_req(0, 1, 104, 3, 1); set_req(1, 1, 105, 3, 2); step("R2");
    set_req(0, 1, 106, 3, 3); set_req(1, 1, 107, 0, 0); step("R2");
    set_req(0, 1, 108, 1, 0); set_req(1, 1, 109, 0, 0);
    #1;
    chk("R2", "last tag port1", alloc_tag_o[1], 9);
    #1 step("R2");

    // R3: pool full, prefetch to second level stalls too
    set_req(0, 1, 200, 3, 1); set_req(1, 0, 0, 0, 0);
    #1;
    chk("R3", "ready when full", req_ready_o[0], 0);
    #1 step("R3");

    // R4: two denials in one cycle
    set_req(0, 1, 200, 0, 0); set_req(1, 1, 201, 1, 0); step("R4");
    idle(); step("R4");

    // R5: merge into live line while full
    set_req(0, 1, 103, 0, 0); set_req(1, 1, 300, 0, 0); step("R5");

    // R11: wrong response kind and out-of-range tag leave entries held
    idle(); set_rsp(1, 0, 1); set_req(0, 1, 200, 0, 0); step("R11");
    set_rsp(1, 12, 2); step("R11");
    set_rsp(0, 0, 3); step("R11");

    // R12: fill frees tag 0 but not for this cycle
    set_rsp(1, 0, 2); set_req(0, 1, 200, 0, 0); step("R12");
    set_rsp(0, 0, 3);
    #1;
    chk("R12", "realloc tag next cycle", alloc_tag_o[0], 0);
    #1 step("R12");

    // R10 and R7: non-temporal store freed by queued; port 0 wins the slot
    idle(); set_rsp(1, 2, 0); step("R10");
    set_rsp(0, 0, 3); set_req(0, 1, 210, 0, 0); set_req(1, 1, 211, 0, 0); step("R7");

    // R9: second-level and last-level prefetches
    idle(); set_rsp(1, 4, 1); step("R9");
    set_rsp(1, 5, 1); step("R9");
    set_rsp(0, 0, 3); set_req(0, 1, 220, 3, 1); set_req(1, 1, 221, 0, 0); step("R9");

    // R8: fill frees store, non-temporal prefetch, first-level prefetch
    idle(); set_rsp(1, 1, 2); step("R8");
    set_rsp(1, 6, 2); step("R8");
    set_rsp(1, 3, 2); step("R8");
    // R6: same line on both ports
    set_rsp(0, 0, 3); set_req(0, 1, 230, 0, 0); set_req(1, 1, 230, 1, 0); step("R6");
    set_req(0, 1, 231, 0, 0); set_req(1, 1, 232, 0, 0); step("R8");

    // R11: fill does not free a second-level prefetch entry
    idle(); set_rsp(1, 4, 2); step("R11");
    set_rsp(0, 0, 3); set_req(0, 1, 240, 0, 0); step("R11");

    // random mix
    for (int c = 0; c < 3000; c++) begin
      for (int p = 0; p < 2; p++)
        set_req(p, ($urandom_range(0, 9) < 6), 500 + $urandom_range(0, 15),
                $urandom_range(0, 3), $urandom_range(0, 3));
      set_rsp(($urandom_range(0, 9) < 7), $urandom_range(0, 11), $urandom_range(0, 3));
      step("random");
    end
    idle(); step("R4");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule